// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte written by the host lands in a one-entry holding register. Whenever the serializer is idle, or is finishing the last stop bit of the previous frame, and the transmit-permit input is high, the byte moves into the serializer. The serializer then sends a low start bit, the data bits least significant first, an optional parity bit and the stop bits. Every bit is timed by a 16x oversampling tick enable supplied from outside.

The line-control inputs choose the frame shape: the word length, parity on or off, odd or even parity, stick parity, one or extended stop time, and a break mode. The frame shape is captured when a byte enters the serializer. In break mode the output is held low while the serializer keeps consuming characters unseen. Two flags report whether the holding register can take a byte, and whether the holding register and the serializer are both empty. Flow control is done by lowering the permit input, which stops the next character from starting without cutting short the one on the line.

Top module: `uatx_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `txd` is 1 and both `hold_empty` and `all_empty` are 1.
- R2: A frame is one start bit at 0 followed by the data bits, least significant bit first. `lc_wlen` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: When `lc_par_en`=1 and `lc_par_stick`=0, one parity bit follows the data bits. `lc_par_even`=0 makes the total count of ones across data and parity odd. `lc_par_even`=1 makes it even. When `lc_par_en`=0, no parity bit is sent.
- R4: When `lc_par_en`=1 and `lc_par_stick`=1, the parity bit is the constant 1 if `lc_par_even`=0, and the constant 0 if `lc_par_even`=1.
- R5: Each bit lasts 16 ticks of `tick16`, and stop bits are 1. With `lc_stop_x`=0 the stop time is 16 ticks. With `lc_stop_x`=1 it is 24 ticks for 5-bit words and 32 ticks for 6, 7 and 8-bit words. When a byte is waiting, the next start bit begins on the tick that ends the previous stop time. Back-to-back frames therefore repeat every (16·(1+data+parity) + stop ticks).
- R6: While `lc_break`=1, `txd` is 0. Characters are still serialized internally, so `all_empty` returns to 1 once they are done. After `lc_break` returns to 0, the idle line shows 1 again.
- R7: A byte moves from the holding register into the serializer only when `tx_permit`=1. If `tx_permit` falls during a frame, that frame still completes, and the next byte stays held.
- R8: `hold_empty` goes to 0 in the cycle after a write and returns to 1 when the byte enters the serializer. `all_empty` is 1 only when the holding register and the serializer are both empty.
- R9: With no frame in progress, `txd` is 1 (outside break). Line-control changes made while a frame is being sent do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16x bit-rate tick enable |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | 8 | Byte to transmit |
| lc_wlen | input | 2 | Word length select (00=5 to 11=8) |
| lc_stop_x | input | 1 | Extended stop time select |
| lc_par_en | input | 1 | Parity enable |
| lc_par_even | input | 1 | Parity type (0 odd, 1 even) |
| lc_par_stick | input | 1 | Stick parity select |
| lc_break | input | 1 | Force the line low |
| tx_permit | input | 1 | Allows the next character to start |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register can accept a byte |
| all_empty | output | 1 | Holding register and serializer both empty |

## Verification
The hardest case to reach from the ports is a permit withdrawal in the middle of a frame while a second byte waits in the holding register. The bench decodes the first frame bit by bit while, in parallel, it writes the second byte and drops the permit partway through. It then watches the line stay idle and the holding register stay full until the permit returns. The exact stop time, including the 24-tick case, is measured start to start between the second and third of three back-to-back frames. Measuring there keeps the tick phase of the very first load out of the count. Break mode is checked by watching `all_empty` come back while `txd` never leaves 0.

// File: rtl/uatx_pkg.sv
package uatx_pkg;
    localparam int WORD_MAX = 8;
    localparam int FRAME_W  = WORD_MAX + 4;
    localparam int NB_W     = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [1:0] wlen;
        logic       stop_x;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } line_cfg_t;
endpackage

// File: rtl/uatx_framer.sv
module uatx_framer
    import uatx_pkg::*;
(
    input  logic [WORD_MAX-1:0] data,
    input  line_cfg_t           cfg,
    output logic [FRAME_W-1:0]  frame,
    output logic [NB_W-1:0]     nbits,
    output logic                last_half
);
    int                  wl;
    logic [WORD_MAX-1:0] kept;
    logic [FRAME_W-1:0]  ext;
    logic                par;

    always_comb begin
        wl = 5 + int'(cfg.wlen);
        for (int i = 0; i < WORD_MAX; i++) begin
            kept[i] = (i < wl) ? data[i] : 1'b0;
        end
        ext = {{(FRAME_W-WORD_MAX){1'b0}}, kept};
        if (cfg.par_stick) begin
            par = ~cfg.par_even;
        end else begin
            par = (^kept) ^ ~cfg.par_even;
        end
        frame[0] = 1'b0;
        for (int j = 1; j < FRAME_W; j++) begin
            if (j <= wl) begin
                frame[j] = ext[j-1];
            end else if ((j == wl + 1) && cfg.par_en) begin
                frame[j] = par;
            end else begin
                frame[j] = 1'b1;
            end
        end
        nbits = NB_W'(wl + 2 + (cfg.par_en ? 1 : 0) + (cfg.stop_x ? 1 : 0));
        last_half = cfg.stop_x && (cfg.wlen == 2'b00);
    end
endmodule

// File: rtl/uatx_hold.sv
module uatx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) begin
            h_d.full = 1'b0;
        end
        if (wr) begin
            h_d.full = 1'b1;
            h_d.data = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign full = h_q.full;
    assign data = h_q.data;
endmodule

// File: rtl/uatx_shifter.sv
module uatx_shifter
    import uatx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               avail,
    input  logic               permit,
    input  logic [FRAME_W-1:0] frame,
    input  logic [NB_W-1:0]    nbits,
    input  logic               last_half,
    output logic               take,
    output logic               busy,
    output logic               ser
);
    localparam int TCW  = $clog2(TICKS_PER_BIT);
    localparam int HALF = TICKS_PER_BIT / 2;

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [NB_W-1:0]    left;
        logic [TCW-1:0]     tcnt;
        logic               half;
    } shf_t;

    shf_t           s_d, s_q;
    logic           finish;
    logic           last;
    logic [TCW-1:0] limit;

    always_comb begin
        s_d    = s_q;
        finish = 1'b0;
        busy   = (s_q.left != '0);
        last   = (s_q.left == NB_W'(1));
        limit  = (last && s_q.half) ? TCW'(HALF - 1) : TCW'(TICKS_PER_BIT - 1);
        if (busy && tick) begin
            if (s_q.tcnt == limit) begin
                s_d.sh   = {1'b1, s_q.sh[FRAME_W-1:1]};
                s_d.left = s_q.left - NB_W'(1);
                s_d.tcnt = '0;
                finish   = last;
            end else begin
                s_d.tcnt = s_q.tcnt + TCW'(1);
            end
        end
        take = avail && permit && (!busy || finish);
        if (take) begin
            s_d.sh   = frame;
            s_d.left = nbits;
            s_d.tcnt = '0;
            s_d.half = last_half;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sh   <= '1;
            s_q.left <= '0;
            s_q.tcnt <= '0;
            s_q.half <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser = s_q.sh[0];
endmodule

// File: rtl/uatx_core.sv
module uatx_core
    import uatx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       hold_wr,
    input  logic [7:0] hold_data,
    input  logic [1:0] lc_wlen,
    input  logic       lc_stop_x,
    input  logic       lc_par_en,
    input  logic       lc_par_even,
    input  logic       lc_par_stick,
    input  logic       lc_break,
    input  logic       tx_permit,
    output logic       txd,
    output logic       hold_empty,
    output logic       all_empty
);
    line_cfg_t           cfg;
    logic                full;
    logic [WORD_MAX-1:0] held;
    logic                take;
    logic                busy;
    logic                ser;
    logic [FRAME_W-1:0]  frame;
    logic [NB_W-1:0]     nbits;
    logic                last_half;

    assign cfg = '{wlen: lc_wlen, stop_x: lc_stop_x, par_en: lc_par_en,
                   par_even: lc_par_even, par_stick: lc_par_stick};

    uatx_hold #(.W(WORD_MAX)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(hold_wr), .wdata(hold_data),
        .take(take), .full(full), .data(held)
    );

    uatx_framer u_framer (
        .data(held), .cfg(cfg), .frame(frame), .nbits(nbits), .last_half(last_half)
    );

    uatx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .avail(full), .permit(tx_permit),
        .frame(frame), .nbits(nbits), .last_half(last_half),
        .take(take), .busy(busy), .ser(ser)
    );

    assign txd        = lc_break ? 1'b0 : (busy ? ser : 1'b1);
    assign hold_empty = !full;
    assign all_empty  = !full && !busy;
endmodule

// File: rtl/uatx_core_chk.sv
module uatx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_wr,
    input logic tx_permit,
    input logic lc_break,
    input logic txd,
    input logic hold_empty,
    input logic all_empty
);
    a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> !hold_empty);

    a_r8_both_implies_hold: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> hold_empty);

    a_r7_load_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> $past(tx_permit));

    a_r7_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && !tx_permit && !hold_wr) |=> !hold_empty);

    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (all_empty && !lc_break) |-> txd);

    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        lc_break |-> !txd);
endmodule

bind uatx_core uatx_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hold_wr(hold_wr), .tx_permit(tx_permit),
    .lc_break(lc_break), .txd(txd), .hold_empty(hold_empty), .all_empty(all_empty)
);

// File: tb/uatx_core_tb.sv
module uatx_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       hold_wr = 1'b0;
    logic [7:0] hold_data = 8'h00;
    logic [1:0] lc_wlen = 2'b00;
    logic       lc_stop_x = 1'b0;
    logic       lc_par_en = 1'b0;
    logic       lc_par_even = 1'b0;
    logic       lc_par_stick = 1'b0;
    logic       lc_break = 1'b0;
    logic       tx_permit = 1'b1;
    logic       txd, hold_empty, all_empty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_div = 1;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick16 <= (tick_div <= 1) || ((cyc % tick_div) == 0);

    uatx_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .hold_wr(hold_wr),
        .hold_data(hold_data), .lc_wlen(lc_wlen), .lc_stop_x(lc_stop_x),
        .lc_par_en(lc_par_en), .lc_par_even(lc_par_even), .lc_par_stick(lc_par_stick),
        .lc_break(lc_break), .tx_permit(tx_permit), .txd(txd),
        .hold_empty(hold_empty), .all_empty(all_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [11:0] build_exp(input logic [7:0] d, input logic [1:0] wl,
            input bit pe, input bit pev, input bit pst, output int nchk, output int ppos);
        int w = 5 + int'(wl);
        int ones = 0;
        logic [11:0] v = '1;
        bit pb;
        v[0] = 1'b0;
        for (int k = 0; k < w; k++) begin
            v[1+k] = d[k];
            ones += int'(d[k]);
        end
        if (pst) pb = !pev;
        else pb = pev ? (ones % 2 == 1) : (ones % 2 == 0);
        ppos = -1;
        if (pe) begin
            v[1+w] = pb;
            ppos = 1 + w;
        end
        nchk = 2 + w + (pe ? 1 : 0);
        return v;
    endfunction

    task automatic set_cfg(input logic [1:0] wl, input bit sx, input bit pe, input bit pev, input bit pst);
        lc_wlen = wl; lc_stop_x = sx; lc_par_en = pe; lc_par_even = pev; lc_par_stick = pst;
    endtask

    task automatic send(input logic [7:0] b);
        while (hold_empty !== 1'b1) @(negedge clk);
        hold_wr = 1'b1;
        hold_data = b;
        @(negedge clk);
        hold_wr = 1'b0;
    endtask

    task automatic rx_frame(input logic [11:0] ev, input int nchk, input int ppos,
                            input bit stick, output int t0);
        while (txd !== 1'b0) @(negedge clk);
        t0 = cyc;
        repeat (8 * tick_div) @(negedge clk);
        for (int j = 0; j < nchk; j++) begin
            if (j == ppos) chk(stick ? "R4 stick parity bit" : "R3 parity bit", txd, ev[j]);
            else if (j == nchk - 1) chk("R5 stop bit", txd, ev[j]);
            else chk("R2 start/data bit", txd, ev[j]);
            if (j < nchk - 1) repeat (16 * tick_div) @(negedge clk);
        end
    endtask

    task automatic settle();
        while (all_empty !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic one_frame(input logic [7:0] b, input logic [1:0] wl, input bit sx,
                             input bit pe, input bit pev, input bit pst);
        int nc, pp, t0;
        logic [11:0] ev;
        set_cfg(wl, sx, pe, pev, pst);
        ev = build_exp(b, wl, pe, pev, pst, nc, pp);
        fork
            send(b);
            rx_frame(ev, nc, pp, pst, t0);
        join
    endtask

    task automatic period_test(input logic [1:0] wl, input bit sx, input bit pe);
        int nc, pp, t0, t1, t2, w, stop_t, expper;
        logic [7:0] b0, b1, b2;
        b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
        set_cfg(wl, sx, pe, 1'b1, 1'b0);
        w = 5 + int'(wl);
        stop_t = sx ? ((w == 5) ? 24 : 32) : 16;
        expper = tick_div * (16 * (1 + w + (pe ? 1 : 0)) + stop_t);
        fork
            begin send(b0); send(b1); send(b2); end
            begin
                rx_frame(build_exp(b0, wl, pe, 1'b1, 1'b0, nc, pp), nc, pp, 1'b0, t0);
                rx_frame(build_exp(b1, wl, pe, 1'b1, 1'b0, nc, pp), nc, pp, 1'b0, t1);
                rx_frame(build_exp(b2, wl, pe, 1'b1, 1'b0, nc, pp), nc, pp, 1'b0, t2);
            end
        join
        chk("R5 back-to-back frame period", 32'(t2 - t1), 32'(expper));
        settle();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int nc, pp, t0, bad;
        logic [11:0] ev;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        chk("R1 txd in reset", txd, 1);
        chk("R1 hold_empty in reset", hold_empty, 1);
        chk("R1 all_empty in reset", all_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd after reset", txd, 1);
        chk("R1 hold_empty after reset", hold_empty, 1);
        chk("R1 all_empty after reset", all_empty, 1);

        // R2 R3 R4: every word length against every parity mode
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 5; pm++) begin
                one_frame(8'($urandom), 2'(wl), 1'b0, pm != 0, (pm == 2) || (pm == 4), pm >= 3);
            end
        end
        one_frame(8'h00, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        one_frame(8'hFF, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        settle();

        // R5: stop time measured start to start, tick every second cycle
        tick_div = 2;
        period_test(2'b00, 1'b1, 1'b0);
        period_test(2'b00, 1'b1, 1'b1);
        period_test(2'b11, 1'b1, 1'b1);
        period_test(2'b01, 1'b0, 1'b0);

        // random frames with random tick spacing
        for (int n = 0; n < 24; n++) begin
            settle();
            tick_div = 1 + int'($urandom % 3);
            one_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom));
        end
        settle();
        tick_div = 1;

        // R9: line control changed mid-frame does not alter it
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        ev = build_exp(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, nc, pp);
        bad = errors;
        fork
            send(8'hA5);
            rx_frame(ev, nc, pp, 1'b0, t0);
            begin repeat (40) @(negedge clk); set_cfg(2'b00, 1'b1, 1'b1, 1'b1, 1'b1); end
        join
        chk("R9 frame kept captured line control", 32'(errors - bad), 0);
        settle();
        bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        chk("R9 idle line high", bad, 0);

        // R7 R8: permit and flags
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        tx_permit = 1'b0;
        send(8'h3C);
        chk("R8 hold_empty after write", hold_empty, 0);
        chk("R8 all_empty after write", all_empty, 0);
        repeat (100) @(negedge clk);
        chk("R7 no start without permit", txd, 1);
        chk("R7 byte stays held", hold_empty, 0);
        tx_permit = 1'b1;
        @(negedge clk);
        chk("R8 hold_empty after load", hold_empty, 1);
        chk("R8 all_empty while shifting", all_empty, 0);
        ev = build_exp(8'h3C, 2'b11, 1'b0, 1'b0, 1'b0, nc, pp);
        fork
            rx_frame(ev, nc, pp, 1'b0, t0);
            begin
                repeat (10) @(negedge clk);
                send(8'h5A);
                chk("R8 hold_empty with shifter busy", hold_empty, 0);
                tx_permit = 1'b0;
            end
        join
        repeat (300) @(negedge clk);
        chk("R7 line idle after permit drop", txd, 1);
        chk("R7 second byte held", hold_empty, 0);
        chk("R8 all_empty with byte held", all_empty, 0);
        tx_permit = 1'b1;
        ev = build_exp(8'h5A, 2'b11, 1'b0, 1'b0, 1'b0, nc, pp);
        rx_frame(ev, nc, pp, 1'b0, t0);
        settle();

        // R6: break hides the frame but shifting goes on
        lc_break = 1'b1;
        send(8'h81);
        bad = 0;
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b0) bad++;
        end
        chk("R6 txd low during break", bad, 0);
        chk("R6 shifting finished unseen", all_empty, 1);
        lc_break = 1'b0;
        @(negedge clk);
        chk("R6 idle high after break", txd, 1);

        summary();
        $finish;
    end
endmodule